// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This unit adds or subtracts two 64-bit operands as a set of independent lanes. A lane-size select splits the word into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. No carry or borrow ever crosses from one lane into the next.

An overflow-mode select decides what each lane does when its result leaves the representable range. In wraparound mode the lane keeps the low bits. In signed-saturating mode the lane clamps to the two's-complement limits. In unsigned-saturating mode the lane clamps to zero or to all ones. Saturation exists only for the 8-bit and 16-bit lane sizes.

A request is accepted with a one-cycle valid strobe. The lane result comes back one clock later with its own valid strobe. Requests that ask for an unsupported combination return a zero result and an error flag.

Top module: `packed_sat_addsub`

## Requirements
- R1: No carry or borrow propagates across a lane boundary. Lane i occupies bits [i*W +: W], where W is the lane width.
- R2: In wraparound mode each lane returns its sum or difference modulo 2^W, for 8-, 16- and 32-bit lanes. For example, an 8-bit lane holding 255 plus 5 returns 4.
- R3: In unsigned-saturating mode an 8-bit or 16-bit lane clamps to 2^W-1 when the true result exceeds it, and to 0 when the true result is negative. For example, 16-bit 10 minus 20 gives 0, and 8516 minus 9343 gives 0.
- R4: In signed-saturating mode an 8-bit lane clamps to -128..127 and a 16-bit lane clamps to -32768..32767.
- R5: The select encodings are as follows, and subtraction always computes opA minus opB:
  - `laneSel`: 0 means 8-bit lanes, 1 means 16-bit lanes, 2 means 32-bit lanes.
  - `modeSel`: 0 means wraparound, 1 means signed saturation, 2 means unsigned saturation.
  - `subSel`: 1 means subtract.
- R6: `outValid` rises on the clock edge after a cycle with `inValid` high, and `result` changes only on that edge. After a cycle with `inValid` low, `outValid` is low and `result` holds its value.
- R7: An illegal request raises `err` together with `outValid` and returns a zero `result`. A request is illegal if any of the following holds:
  - saturation is requested on 32-bit lanes;
  - `laneSel` is 3;
  - `modeSel` is 3.
- R8: While reset is held, `outValid`, `err` and `result` are all 0.
- R9: For 8-bit and 16-bit lanes, the OR of the unsigned-saturated results of opA-opB and opB-opA equals the per-lane absolute difference of the two operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opA | input | 64 | First operand, minuend for subtraction |
| opB | input | 64 | Second operand |
| subSel | input | 1 | 1 = subtract, 0 = add |
| laneSel | input | 2 | Lane size select |
| modeSel | input | 2 | Overflow mode select |
| outValid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Lane-wise result |
| err | output | 1 | Illegal request flag, qualified by outValid |

## Verification
A wrong decoded strobe or a stray carry in a lane adder shows up in `result` on the very next clock edge after the request. It appears as a corrupted neighbouring lane, a lane that wraps where it should clamp, or a clamp to the wrong limit. A stuck valid or error register shows up on the same edge, as a missing or extra `outValid` or `err`, or as a non-zero `result` beside `err`. The bench therefore checks every transaction exactly one cycle after issue. It uses carry-provoking values at each lane boundary and at both clamp limits.

// File: rtl/psau_pkg.sv
package psau_pkg;

  typedef enum logic [1:0] {
    LANE_8   = 2'd0,
    LANE_16  = 2'd1,
    LANE_32  = 2'd2,
    LANE_BAD = 2'd3
  } laneSize_e;

  typedef enum logic [1:0] {
    OV_WRAP = 2'd0,
    OV_SSAT = 2'd1,
    OV_USAT = 2'd2,
    OV_BAD  = 2'd3
  } ovMode_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic load;
    logic illegal;
    logic selNarrow;
    logic selMid;
    logic selWide;
    logic doSub;
    logic satSigned;
    logic satUnsigned;
  } ctrlStrobes_t;

endpackage

// File: rtl/psau_lane.sv
module psau_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         satS,
  input  logic         satU,
  output logic [W-1:0] y
);

  logic [W:0] uExt;
  logic [W:0] sExt;

  always_comb begin
    // One extra bit catches the unsigned carry/borrow and signed overflow
    uExt = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    sExt = sub ? ({a[W-1], a} - {b[W-1], b}) : ({a[W-1], a} + {b[W-1], b});
    y = uExt[W-1:0];
    if (satU && uExt[W]) begin
      y = sub ? '0 : '1;
    end else if (satS && (sExt[W] != sExt[W-1])) begin
      y = sExt[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end
  end

endmodule

// File: rtl/psau_ctrl.sv
module psau_ctrl
  import psau_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         subSel,
  input  logic [1:0]   laneSel,
  input  logic [1:0]   modeSel,
  output ctrlStrobes_t strobes,
  output logic         outValid,
  output logic         err
);

  always_comb begin
    strobes = '0;
    strobes.load  = inValid;
    strobes.doSub = subSel;
    unique case (laneSize_e'(laneSel))
      LANE_8:   strobes.selNarrow = 1'b1;
      LANE_16:  strobes.selMid    = 1'b1;
      LANE_32:  strobes.selWide   = 1'b1;
      default:  strobes.illegal   = 1'b1;
    endcase
    unique case (ovMode_e'(modeSel))
      OV_WRAP: ;
      OV_SSAT: strobes.satSigned   = 1'b1;
      OV_USAT: strobes.satUnsigned = 1'b1;
      default: strobes.illegal     = 1'b1;
    endcase
    if (strobes.selWide && (strobes.satSigned || strobes.satUnsigned)) begin
      strobes.illegal = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      err      <= 1'b0;
    end else begin
      outValid <= inValid;
      err      <= inValid && strobes.illegal;
    end
  end

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R7
  wide_sat_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneSel == 2'd2 && modeSel != 2'd0) |=> err);

endmodule

// File: rtl/psau_dp.sv
module psau_dp
  import psau_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  localparam int NarrowW = BYTE_W;
  localparam int MidW    = 2 * BYTE_W;
  localparam int WideW   = 4 * BYTE_W;
  localparam int NarrowN = DATA_W / NarrowW;
  localparam int MidN    = DATA_W / MidW;
  localparam int WideN   = DATA_W / WideW;

  logic [DATA_W-1:0] narrowRes;
  logic [DATA_W-1:0] midRes;
  logic [DATA_W-1:0] wideRes;
  logic [DATA_W-1:0] nextRes;

  for (genvar i = 0; i < NarrowN; i++) begin : g_narrow
    psau_lane #(.W(NarrowW)) u_lane (
      .a(opA[i*NarrowW +: NarrowW]), .b(opB[i*NarrowW +: NarrowW]),
      .sub(strobes.doSub), .satS(strobes.satSigned), .satU(strobes.satUnsigned),
      .y(narrowRes[i*NarrowW +: NarrowW]));
  end

  for (genvar i = 0; i < MidN; i++) begin : g_mid
    psau_lane #(.W(MidW)) u_lane (
      .a(opA[i*MidW +: MidW]), .b(opB[i*MidW +: MidW]),
      .sub(strobes.doSub), .satS(strobes.satSigned), .satU(strobes.satUnsigned),
      .y(midRes[i*MidW +: MidW]));
  end

  // Wide lanes never saturate; illegal requests are zeroed below
  for (genvar i = 0; i < WideN; i++) begin : g_wide
    psau_lane #(.W(WideW)) u_lane (
      .a(opA[i*WideW +: WideW]), .b(opB[i*WideW +: WideW]),
      .sub(strobes.doSub), .satS(1'b0), .satU(1'b0),
      .y(wideRes[i*WideW +: WideW]));
  end

  always_comb begin
    if (strobes.illegal)        nextRes = '0;
    else if (strobes.selNarrow) nextRes = narrowRes;
    else if (strobes.selMid)    nextRes = midRes;
    else                        nextRes = wideRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             result <= '0;
    else if (strobes.load) result <= nextRes;
  end

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(result));

endmodule

// File: rtl/packed_sat_addsub.sv
module packed_sat_addsub
  import psau_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              subSel,
  input  logic [1:0]        laneSel,
  input  logic [1:0]        modeSel,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              err
);

  ctrlStrobes_t strobes;

  psau_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .subSel(subSel),
    .laneSel(laneSel), .modeSel(modeSel),
    .strobes(strobes), .outValid(outValid), .err(err));

  psau_dp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .opA(opA), .opB(opB), .result(result));

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (result == '0));

  // R7
  err_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> outValid);

endmodule

// File: tb/sim_packed_sat_addsub.sv
`timescale 1ns/1ps
module sim_packed_sat_addsub;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        subSel = 1'b0;
  logic [1:0]  laneSel = 2'd0;
  logic [1:0]  modeSel = 2'd0;
  logic        outValid;
  logic [63:0] result;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  packed_sat_addsub u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .subSel(subSel), .laneSel(laneSel), .modeSel(modeSel),
    .outValid(outValid), .result(result), .err(err));

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic sub, input logic [1:0] lane,
                                        input logic [1:0] mode);
    int w;
    logic [63:0] res;
    longint msk;
    w = (lane == 2'd0) ? 8 : (lane == 2'd1) ? 16 : 32;
    msk = (longint'(1) << w) - 1;
    res = '0;
    for (int k = 0; k < 64 / w; k++) begin
      longint ua, ub, sa, sb, r;
      ua = longint'((a >> (k * w)) & 64'(msk));
      ub = longint'((b >> (k * w)) & 64'(msk));
      if (mode == 2'd1) begin
        sa = ua[w-1] ? ua - (longint'(1) << w) : ua;
        sb = ub[w-1] ? ub - (longint'(1) << w) : ub;
        r = sub ? sa - sb : sa + sb;
        if (r > (longint'(1) << (w - 1)) - 1) r = (longint'(1) << (w - 1)) - 1;
        if (r < -(longint'(1) << (w - 1))) r = -(longint'(1) << (w - 1));
      end else begin
        r = sub ? ua - ub : ua + ub;
        if (mode == 2'd2) begin
          if (r > msk) r = msk;
          if (r < 0) r = 0;
        end
      end
      res = res | (64'(r & msk) << (k * w));
    end
    return res;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // Drive one request at a falling edge; return after the following falling edge
  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic sub,
                       input logic [1:0] lane, input logic [1:0] mode);
    @(negedge clk);
    opA = a; opB = b; subSel = sub; laneSel = lane; modeSel = mode; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runOp(input string tag, input logic [63:0] a, input logic [63:0] b,
                       input logic sub, input logic [1:0] lane, input logic [1:0] mode);
    issue(a, b, sub, lane, mode);
    chk(tag, "outValid", 64'(outValid), 64'd1);
    chk(tag, "err", 64'(err), 64'd0);
    chk(tag, "result", result, model(a, b, sub, lane, mode));
  endtask

  task automatic testReset();
    chk("R8", "outValid in reset", 64'(outValid), 64'd0);
    chk("R8", "err in reset", 64'(err), 64'd0);
    chk("R8", "result in reset", result, 64'd0);
  endtask

  task automatic testWrap();
    // R2 and R1: 255+5 wraps to 4 without touching the neighbouring lane
    issue(64'h0800_0500_FF00_012D, 64'h0039_0500_0500_0102, 1'b0, 2'd0, 2'd0);
    chk("R2", "byte wrap example", result, 64'h0839_0A00_0400_022F);
    runOp("R1", 64'hFFFF_0001_FFFF_7FFF, 64'h0001_FFFF_0001_0001, 1'b0, 2'd1, 2'd0);
    issue(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0, 2'd2, 2'd0);
    chk("R1", "dword carry stays in lane", result, 64'h0);
    runOp("R2", 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0002, 1'b1, 2'd2, 2'd0);
  endtask

  task automatic testOrder();
    issue(64'h03, 64'h05, 1'b1, 2'd0, 2'd0);
    chk("R5", "opA minus opB", result, 64'h0000_0000_0000_00FE);
    issue(64'h05, 64'h03, 1'b1, 2'd0, 2'd0);
    chk("R5", "reversed order", result, 64'h02);
  endtask

  task automatic testUnsigned();
    issue({16'd1234, 16'd10, 16'd5, 16'd8516}, {16'd1, 16'd20, 16'd1, 16'd9343},
          1'b1, 2'd1, 2'd2);
    chk("R3", "word sub clamps at 0", result, {16'd1233, 16'd0, 16'd4, 16'd0});
    issue(64'hFF10_F000_0102_0304, 64'h0220_2000_FF02_0304, 1'b0, 2'd0, 2'd2);
    chk("R3", "byte add clamps at 255", result, 64'hFF30_FF00_FF04_0608);
    runOp("R3", 64'hFFFF_8000_0001_0000, 64'h0001_8000_0002_0000, 1'b0, 2'd1, 2'd2);
  endtask

  task automatic testSigned();
    issue({8{8'h64}}, {8{8'h64}}, 1'b0, 2'd0, 2'd1);
    chk("R4", "byte clamps at 127", result, {8{8'h7F}});
    issue({8{8'h9C}}, {8{8'h9C}}, 1'b0, 2'd0, 2'd1);
    chk("R4", "byte clamps at -128", result, {8{8'h80}});
    issue({16'h8000, 16'h7FFF, 16'h0005, 16'hFFFB}, {16'h0001, 16'hFFFF, 16'h0003, 16'h0003},
          1'b1, 2'd1, 2'd1);
    chk("R4", "word signed sub", result, {16'h8000, 16'h7FFF, 16'h0002, 16'hFFF8});
  endtask

  task automatic testIllegal();
    issue(64'h1234, 64'h1, 1'b0, 2'd2, 2'd2);
    chk("R7", "dword unsigned sat err", 64'(err), 64'd1);
    chk("R7", "dword sat result zero", result, 64'd0);
    chk("R7", "outValid with err", 64'(outValid), 64'd1);
    issue(64'h1234, 64'h1, 1'b0, 2'd2, 2'd1);
    chk("R7", "dword signed sat err", 64'(err), 64'd1);
    issue(64'h1234, 64'h1, 1'b0, 2'd3, 2'd0);
    chk("R7", "lane code 3 err", 64'(err), 64'd1);
    issue(64'h1234, 64'h1, 1'b0, 2'd0, 2'd3);
    chk("R7", "mode code 3 err", 64'(err), 64'd1);
    chk("R7", "mode code 3 result", result, 64'd0);
  endtask

  task automatic testIdle();
    logic [63:0] held;
    issue(64'h0102_0304_0506_0708, 64'h0101_0101_0101_0101, 1'b0, 2'd0, 2'd0);
    held = result;
    chk("R6", "result after issue", held, 64'h0203_0405_0607_0809);
    @(negedge clk);
    opA = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    chk("R6", "outValid low when idle", 64'(outValid), 64'd0);
    chk("R6", "result held when idle", result, held);
    chk("R6", "err low when idle", 64'(err), 64'd0);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    opA = 64'h10; opB = 64'h20; subSel = 1'b0; laneSel = 2'd0; modeSel = 2'd0;
    inValid = 1'b1;
    @(negedge clk);
    chk("R6", "first of pair", result, 64'h30);
    chk("R6", "first of pair valid", 64'(outValid), 64'd1);
    opA = 64'h5; opB = 64'h7; subSel = 1'b1; laneSel = 2'd1; modeSel = 2'd2;
    @(negedge clk);
    inValid = 1'b0;
    chk("R6", "second of pair", result, 64'h0);
    chk("R6", "second of pair valid", 64'(outValid), 64'd1);
    @(negedge clk);
    chk("R6", "valid drops after pair", 64'(outValid), 64'd0);
  endtask

  task automatic testAbsDiff(input logic [1:0] lane);
    logic [63:0] a, b, d1, d2, exp;
    int w;
    a = 64'h0F80_FF00_1234_7001;
    b = 64'h8010_00FF_3412_6F02;
    w = (lane == 2'd0) ? 8 : 16;
    issue(a, b, 1'b1, lane, 2'd2);
    d1 = result;
    issue(b, a, 1'b1, lane, 2'd2);
    d2 = result;
    exp = '0;
    for (int k = 0; k < 64 / w; k++) begin
      longint ua, ub, dd;
      ua = longint'((a >> (k * w)) & ((64'd1 << w) - 1));
      ub = longint'((b >> (k * w)) & ((64'd1 << w) - 1));
      dd = (ua > ub) ? ua - ub : ub - ua;
      exp = exp | (64'(dd) << (k * w));
    end
    chk("R9", "absolute difference identity", d1 | d2, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testWrap();
    testOrder();
    testUnsigned();
    testSigned();
    testIllegal();
    testIdle();
    testBackToBack();
    testAbsDiff(2'd0);
    testAbsDiff(2'd1);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule